// File: doc/BRIEF.md
# Ling Pseudo-Carry Adder

A combinational two-operand binary adder that forms a sum vector and a carry-out from two operand vectors and a carry-in. It does not propagate true carries through its lookahead logic. Instead it propagates Ling pseudo-carries H, where H at a bit position is the carry into that position with its transfer factor taken out. This lets every lookahead product term use one literal fewer than the conventional carry lookahead would need.

Each bit forms generate `g = a & b` and transfer `t = a | b`. Groups of four bits reduce these to a group pseudo-generate and a group transfer. An associative prefix network combines the groups to produce H at every group boundary, starting from the carry-in. Each group then expands H back into its inner positions. A sum bit either selects on H directly or rebuilds the true carry first, depending on a parameter. The default width is 64 bits. A 32-bit instance and other multiples of four are supported.

Top module: `ling_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals `a_i + b_i + cin_i` as an unsigned sum of WIDTH+1 bits, for the default WIDTH of 64 and for WIDTH 32.
- R2: Per bit, generate is `a & b` and transfer is `a | b`. A bit with generate set forces the pseudo-carry of the next position to 1.
- R3: The true carry into bit i is `t(i-1) & H(i)`. The carry-in acts as H(0), with a transfer of 1 below bit 0. The carry-out is `t(WIDTH-1) & H(WIDTH)`.
- R4: Every pseudo-carry product term inside a 4-bit group has at most 4 literals. A group with no generate bit produces no group pseudo-generate.
- R5: Group boundary pseudo-carries come from an associative prefix of (pseudo-generate, transfer) pairs. A group whose pseudo-generate is set forces the pseudo-carry at its upper boundary to 1.
- R6: SUM_MODE 1 forms each sum bit by a 2:1 select on H(i). SUM_MODE 0 forms the true carry and XORs it in. Both modes give the R1 result, which is checked exhaustively at WIDTH 8 in mode 0.
- R7: All-ones plus zero with carry-in 1 gives sum 0 and carry-out 1. All-ones plus all-ones with carry-in 1 gives all-ones and carry-out 1. A pattern that transfers on every bit with no generate passes the carry-in to the carry-out.
- R8: WIDTH must be a multiple of 4. Width 8 is correct over every operand pair and both carry-in values.
- R9: The block has no clock or state. Outputs depend only on the current inputs, and all-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in, used as H(0) |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry-out |

## Verification
Two sources can set the same boundary pseudo-carry at once: a carry-in carried across a run of transfer-only groups, and a generate inside one of those groups. Both are provoked together with patterns such as all-ones plus carry-in, alternating bit patterns that transfer on every bit with a generate placed in the top group, and an exhaustive 8-bit sweep in which every overlap occurs. Results are judged against an independent integer sum of WIDTH+1 bits, and in-RTL checks test the generate-implies-H relations at the bit and group levels.

// File: rtl/ling_pkg.sv
package ling_pkg;
  localparam int unsigned GRP_W = 4;

  typedef struct packed {
    logic h;  // pseudo-generate
    logic t;  // transfer
  } ling_pair_t;

  // hi spans upper bits, lo spans the lower adjacent range
  function automatic ling_pair_t ling_merge(input ling_pair_t hi, input ling_pair_t lo);
    ling_pair_t r;
    r.h = hi.h | (hi.t & lo.h);
    r.t = hi.t & lo.t;
    return r;
  endfunction
endpackage

// File: rtl/ling_bitstage.sv
module ling_bitstage #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] t_o,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] tm1_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign g_o[i] = a_i[i] & b_i[i];
    assign t_o[i] = a_i[i] | b_i[i];
    assign x_o[i] = a_i[i] ^ b_i[i];
    if (i == 0) begin : g_lsb
      assign tm1_o[i] = 1'b1;
    end else begin : g_up
      assign tm1_o[i] = t_o[i-1];
    end
  end
endmodule

// File: rtl/ling_group4.sv
module ling_group4 (
  input  logic [3:0] g_i,
  input  logic [2:0] t_i,
  input  logic       tm1_i,
  input  logic       h_in_i,
  output logic       gh_o,
  output logic       gt_o,
  output logic [3:0] h_o
);
  // every term below is at most 4 literals
  assign h_o[0] = h_in_i;
  assign h_o[1] = g_i[0] | (tm1_i & h_in_i);
  assign h_o[2] = g_i[1] | g_i[0] | (t_i[0] & tm1_i & h_in_i);
  assign h_o[3] = g_i[2] | g_i[1] | (t_i[1] & g_i[0]) | (t_i[1] & t_i[0] & tm1_i & h_in_i);

  assign gh_o = g_i[3] | g_i[2] | (t_i[2] & g_i[1]) | (t_i[2] & t_i[1] & g_i[0]);
  assign gt_o = t_i[2] & t_i[1] & t_i[0] & tm1_i;

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      // R2: generate forces the next pseudo-carry
      a_r2_gen_sets_h: assert (!g_i[k] || h_o[k+1])
        else $error("generate without pseudo-carry at %0d", k);
    end
    // R4: no generate in the group means no group pseudo-generate
    a_r4_quiet_group: assert (g_i != 4'b0000 || !gh_o)
      else $error("group pseudo-generate without generate");
  end
endmodule

// File: rtl/ling_prefix.sv
module ling_prefix
  import ling_pkg::*;
#(
  parameter int unsigned NG = 16
) (
  input  logic [NG-1:0] gh_i,
  input  logic [NG-1:0] gt_i,
  input  logic          cin_i,
  output logic [NG:0]   hb_o
);
  localparam int unsigned LVL = (NG > 1) ? $clog2(NG) : 0;

  ling_pair_t [LVL:0][NG-1:0] pr;

  for (genvar k = 0; k < NG; k++) begin : g_init
    assign pr[0][k] = '{h: gh_i[k], t: gt_i[k]};
  end

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int unsigned D = 1 << l;
    for (genvar k = 0; k < NG; k++) begin : g_node
      if (k >= D) begin : g_op
        assign pr[l+1][k] = ling_merge(pr[l][k], pr[l][k-D]);
      end else begin : g_pass
        assign pr[l+1][k] = pr[l][k];
      end
    end
  end

  assign hb_o[0] = cin_i;
  for (genvar k = 0; k < NG; k++) begin : g_out
    assign hb_o[k+1] = pr[LVL][k].h | (pr[LVL][k].t & cin_i);
  end

  always_comb begin
    for (int k = 0; k < NG; k++) begin
      // R5: a group pseudo-generate sets its upper boundary
      a_r5_group_sets_boundary: assert (!gh_i[k] || hb_o[k+1])
        else $error("boundary %0d missing pseudo-carry", k + 1);
    end
  end
endmodule

// File: rtl/ling_sum.sv
module ling_sum #(
  parameter int unsigned WIDTH    = 64,
  parameter int unsigned SUM_MODE = 1
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] tm1_i,
  input  logic [WIDTH-1:0] h_i,
  input  logic             tn_i,
  input  logic             hn_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  if (SUM_MODE == 1) begin : g_select
    // true carry never built: pick x or x^t(i-1) on H
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign sum_o[i] = h_i[i] ? (x_i[i] ^ tm1_i[i]) : x_i[i];
    end
  end else begin : g_carry
    logic [WIDTH-1:0] c;
    assign c     = tm1_i & h_i;
    assign sum_o = x_i ^ c;
  end

  assign cout_o = tn_i & hn_i;
endmodule

// File: rtl/ling_adder.sv
module ling_adder
  import ling_pkg::*;
#(
  parameter int unsigned WIDTH    = 64,
  parameter int unsigned SUM_MODE = 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NG = WIDTH / GRP_W;

  if ((WIDTH % GRP_W) != 0 || WIDTH == 0) begin : g_bad_width
    $error("WIDTH must be a nonzero multiple of 4");
  end

  logic [WIDTH-1:0] g, t, x, tm1, h;
  logic [NG-1:0]    gh, gt;
  logic [NG:0]      hb;

  ling_bitstage #(.WIDTH(WIDTH)) i_bits (
    .a_i  (a_i),
    .b_i  (b_i),
    .g_o  (g),
    .t_o  (t),
    .x_o  (x),
    .tm1_o(tm1)
  );

  for (genvar k = 0; k < NG; k++) begin : g_grp
    ling_group4 i_grp (
      .g_i   (g[GRP_W*k +: GRP_W]),
      .t_i   (t[GRP_W*k +: GRP_W-1]),
      .tm1_i (tm1[GRP_W*k]),
      .h_in_i(hb[k]),
      .gh_o  (gh[k]),
      .gt_o  (gt[k]),
      .h_o   (h[GRP_W*k +: GRP_W])
    );
  end

  ling_prefix #(.NG(NG)) i_prefix (
    .gh_i (gh),
    .gt_i (gt),
    .cin_i(cin_i),
    .hb_o (hb)
  );

  ling_sum #(.WIDTH(WIDTH), .SUM_MODE(SUM_MODE)) i_sum (
    .x_i   (x),
    .tm1_i (tm1),
    .h_i   (h),
    .tn_i  (t[WIDTH-1]),
    .hn_i  (hb[NG]),
    .sum_o (sum_o),
    .cout_o(cout_o)
  );

  always_comb begin
    // R1: result against an integer sum
    a_r1_sum_matches: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("sum mismatch");
    // R3: carry-out needs the top pseudo-carry
    a_r3_cout_needs_h: assert (!cout_o || hb[NG])
      else $error("carry-out without pseudo-carry");
    // R2: top bit generate forces H(WIDTH)
    a_r2_top_gen: assert (!g[WIDTH-1] || hb[NG])
      else $error("top generate without pseudo-carry");
  end
endmodule

// File: tb/test_ling_adder.sv
module test_ling_adder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] a64, b64, s64;
  logic [31:0] a32, b32, s32;
  logic [7:0]  a8, b8, s8;
  logic        cin, c64, c32, c8;

  ling_adder i_ling_adder (.a_i(a64), .b_i(b64), .cin_i(cin), .sum_o(s64), .cout_o(c64));
  ling_adder #(.WIDTH(32), .SUM_MODE(1)) i_ling_adder_w32 (
    .a_i(a32), .b_i(b32), .cin_i(cin), .sum_o(s32), .cout_o(c32));
  ling_adder #(.WIDTH(8), .SUM_MODE(0)) i_ling_adder_w8 (
    .a_i(a8), .b_i(b8), .cin_i(cin), .sum_o(s8), .cout_o(c8));

  typedef struct {
    logic [64:0] e64;
    logic [32:0] e32;
    logic [8:0]  e8;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t m;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic c,
                       input logic [31:0] x, input logic [31:0] y,
                       input logic [7:0] u, input logic [7:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    a64 = a; b64 = b; cin = c; a32 = x; b32 = y; a8 = u; b8 = v;
    e.e64 = {1'b0, a} + {1'b0, b} + {64'd0, c};
    e.e32 = {1'b0, x} + {1'b0, y} + {32'd0, c};
    e.e8  = {1'b0, u} + {1'b0, v} + {8'd0, c};
    e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // monitor: inputs settle at negedge, compare at the next posedge
  always @(posedge clk) begin
    if (q.size() > 0) begin
      m = q.pop_front();
      checks += 3;
      if ({c64, s64} !== m.e64) begin
        errors++;
        $display("FAIL %s w64 got %h_%h exp %h", m.tag, c64, s64, m.e64);
      end
      if ({c32, s32} !== m.e32) begin
        errors++;
        $display("FAIL %s w32 got %h_%h exp %h", m.tag, c32, s32, m.e32);
      end
      if ({c8, s8} !== m.e8) begin
        errors++;
        $display("FAIL %s w8 got %h_%h exp %h", m.tag, c8, s8, m.e8);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a64 = '0; b64 = '0; a32 = '0; b32 = '0; a8 = '0; b8 = '0; cin = 1'b0;
    // R9: all zero inputs, zero outputs
    drive('0, '0, 1'b0, '0, '0, '0, '0, "R9");
    // R7: all-ones boundaries and full transfer chains
    drive('1, '0, 1'b1, '1, '0, 8'hff, 8'h00, "R7");
    drive('1, '1, 1'b1, '1, '1, 8'hff, 8'hff, "R7");
    drive('1, '0, 1'b0, '1, '0, 8'hff, 8'h00, "R7");
    drive(64'h5555_5555_5555_5555, 64'haaaa_aaaa_aaaa_aaaa, 1'b1,
          32'h5555_5555, 32'haaaa_aaaa, 8'h55, 8'haa, "R7");
    drive(64'h5555_5555_5555_5555, 64'haaaa_aaaa_aaaa_aaaa, 1'b0,
          32'h5555_5555, 32'haaaa_aaaa, 8'h55, 8'haa, "R7");
    // R2: generate only in the top bit
    drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0,
          32'h8000_0000, 32'h8000_0000, 8'h80, 8'h80, "R2");
    // R5: carry-in chain overlapping a generate in the top group
    drive(64'hf555_5555_5555_5555, 64'h1aaa_aaaa_aaaa_aaaa, 1'b1,
          32'hf555_5555, 32'h1aaa_aaaa, 8'hf5, 8'h1a, "R5");
    // R4: generate at each group's low bit, transfer above it
    drive(64'h1111_1111_1111_1111, 64'hffff_ffff_ffff_ffff, 1'b0,
          32'h1111_1111, 32'hffff_ffff, 8'h11, 8'hff, "R4");
    // R3: single transfer gap stops the carry
    drive(64'hffff_fffe_ffff_ffff, 64'h0, 1'b1, 32'hfffe_ffff, 32'h0, 8'hfe, 8'h01, "R3");
    // R1: random 64/32
    for (int n = 0; n < 2000; n++) begin
      logic [63:0] ra, rb;
      ra = rnd64(); rb = rnd64();
      drive(ra, rb, n[0], ra[63:32], rb[31:0], ra[7:0], rb[15:8], "R1");
    end
    // R8 and R6: exhaustive 8-bit with carry-in, mode 0 instance
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        for (int ic = 0; ic < 2; ic++) begin
          logic [63:0] ra;
          ra = rnd64();
          drive(ra, ~ra, ic[0], ra[31:0], ra[63:32], ia[7:0], ib[7:0], "R8");
        end
      end
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule